// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a simple synchronous request port and an external 1M x 16 extended-data-out DRAM that has separate strobes for its low and high byte. The host presents a 20-bit word address, 16-bit write data, a 2-bit byte mask and a read/write flag. The controller turns each request into the row-strobe, column-strobe and multiplexed address sequence the DRAM needs. Read data comes back on a result port with a one-cycle valid pulse.

After an access, the row stays open. A later request to the same row is served by a column strobe alone, in page mode, and reads and writes may be mixed within one open row. A request to another row first closes the open row, waits out precharge and then opens the new row. A refresh grant from an external scheduler takes priority over new requests. The controller closes any open row and runs a column-before-row refresh cycle. Every DRAM timing limit is a parameter counted in clock cycles.

Top module: `edo_ctrl`

## Requirements
- R1: The row half of the address, req_addr[19:10], is on dram_addr while dram_ras_n falls. The column half, req_addr[9:0], is on dram_addr while a column strobe falls.
- R2: A request whose row matches the open row is served without a new row-strobe fall (page mode).
- R3: A request to a different row causes exactly one extra row-strobe fall, after the old row is closed.
- R4: Once dram_ras_n falls, it stays low for at least T_RAS cycles.
- R5: dram_ras_n stays high for at least T_RP cycles before it falls again.
- R6: Both column strobes stay high together for at least T_CP cycles before either one falls.
- R7: On a write, dram_lcas_n falls only if req_mask[0] is 1 and dram_ucas_n only if req_mask[1] is 1. The low strobe writes dq[7:0] and the high strobe writes dq[15:8]. dram_we_n is low and the write data is driven from the same edge on which the strobes fall. dram_dq_oe is high only while dram_we_n is low and dram_oe_n is high.
- R8: On a read, both column strobes fall and dram_oe_n is low. The word is captured T_CAC cycles after the strobe falls, or earlier if another column strobe or the row close comes first. It is returned on rd_data with a one-cycle rd_valid pulse. Reads return in request order and reflect all earlier writes.
- R9: While ref_grant is high, no new request is accepted. The controller closes any open row, holds both column strobes low for T_CSR cycles, then drops dram_ras_n for T_RAS cycles and pulses ref_done in the final cycle.
- R10: During and right after reset, dram_ras_n, both column strobes, dram_we_n and dram_oe_n are high, and dram_dq_oe and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte enables for writes, bit 0 low byte |
| req_ready | output | 1 | Request accepted on this edge when req_valid is high |
| rd_valid | output | 1 | One-cycle read result pulse |
| rd_data | output | 16 | Read result |
| ref_grant | input | 1 | Refresh requested, held until ref_done |
| ref_done | output | 1 | Refresh cycle finishing |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
Every cycle, the bound checker enforces the minimum row-strobe low and high times and the column precharge time. It also checks that a read drives both byte strobes, that a row-strobe fall with a column strobe low was preceded by both column strobes low, and that data is driven only during a write. Only the bench scenarios can show the other behaviours: that page hits avoid a new row open, that a row change adds exactly one, that masked writes leave the other byte intact, and that returned read words match the stored data in order. The bench gets these from a pin-level DRAM model, checked against its own shadow memory.

// File: rtl/edo_pkg.sv
package edo_pkg;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int DATA_W = 16;
    localparam int LANES  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_CAS,
        ST_OPEN,
        ST_CLOSE,
        ST_RF_CAS,
        ST_RF_RAS
    } st_e;

    typedef struct packed {
        logic              write;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
    } acc_t;

    // Byte strobes that go low for an access: mask on writes, all on reads.
    function automatic logic [LANES-1:0] lane_sel(input logic write, input logic [LANES-1:0] mask);
        return write ? mask : '1;
    endfunction

    function automatic logic row_held(input st_e s);
        return (s == ST_ROW) || (s == ST_CAS) || (s == ST_OPEN) ||
               (s == ST_CLOSE) || (s == ST_RF_RAS);
    endfunction
endpackage

// File: rtl/edo_age.sv
module edo_age #(
    parameter int LIMIT      = 8,
    parameter bit START_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic ok
);
    localparam int         W   = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= START_FULL ? TOP : '0;
        else if (clr)       age <= '0;
        else if (age != TOP) age <= age + 1'b1;
    end

    // Cycles spent so far, the current one included, reach LIMIT.
    assign ok = (32'(age) + 32'd1) >= 32'(LIMIT);
endmodule

// File: rtl/edo_row_track.sv
module edo_row_track import edo_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] req_row,
    output logic             hit
);
    logic             live;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live  <= 1'b0;
            row_q <= '0;
        end else if (open_set) begin
            live  <= 1'b1;
            row_q <= row_in;
        end else if (close) begin
            live  <= 1'b0;
        end
    end

    assign hit = live && (row_q == req_row);
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl import edo_pkg::*; #(
    parameter int T_RCD = 3,
    parameter int T_CAS = 2,
    parameter int T_CP  = 2,
    parameter int T_RAS = 12,
    parameter int T_RP  = 8,
    parameter int T_CAC = 3,
    parameter int T_CSR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_grant,
    output logic              ref_done,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_lcas_n,
    output logic              dram_ucas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int CNT_W = $clog2(T_RCD + T_CAS + T_RAS + T_CAC + T_CSR + 1);
    localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
    localparam logic [CNT_W-1:0] L_CAC = CNT_W'(T_CAC - 1);
    localparam logic [CNT_W-1:0] L_CSR = CNT_W'(T_CSR - 1);

    st_e              st, st_nx;
    acc_t             cur, incoming;
    logic [CNT_W-1:0] st_cnt, rd_cnt;
    logic [LANES-1:0] lanes_lo;
    logic             ras_low, cas_any_low;
    logic             ras_ok, pre_ok, cp_ok, hit;
    logic             accept, go_cas, leave_row, nxt_write, rd_pend;

    assign incoming = '{write: req_write, row: req_addr[ADDR_W-1:COL_W],
                        col: req_addr[COL_W-1:0], wdata: req_wdata, mask: req_mask};

    assign ras_low = row_held(st);

    always_comb begin
        case (st)
            ST_CAS:               lanes_lo = lane_sel(cur.write, cur.mask);
            ST_RF_CAS, ST_RF_RAS: lanes_lo = '1;
            default:              lanes_lo = '0;
        endcase
    end
    assign cas_any_low = |lanes_lo;

    edo_age #(.LIMIT(T_RAS), .START_FULL(1'b0)) u_ras_age (
        .clk(clk), .rst(rst), .clr(!ras_low), .ok(ras_ok));
    edo_age #(.LIMIT(T_RP), .START_FULL(1'b1)) u_pre_age (
        .clk(clk), .rst(rst), .clr(ras_low), .ok(pre_ok));
    edo_age #(.LIMIT(T_CP), .START_FULL(1'b1)) u_cp_age (
        .clk(clk), .rst(rst), .clr(cas_any_low), .ok(cp_ok));

    edo_row_track u_rows (
        .clk(clk), .rst(rst),
        .open_set(accept && (st == ST_IDLE)),
        .close(leave_row),
        .row_in(incoming.row),
        .req_row(incoming.row),
        .hit(hit));

    always_comb begin
        st_nx     = st;
        accept    = 1'b0;
        req_ready = 1'b0;
        ref_done  = 1'b0;
        case (st)
            ST_IDLE: begin
                req_ready = pre_ok && cp_ok && !ref_grant;
                if (ref_grant && pre_ok && cp_ok) st_nx = ST_RF_CAS;
                else if (req_valid && req_ready) begin
                    accept = 1'b1;
                    st_nx  = ST_ROW;
                end
            end
            ST_ROW:  if (st_cnt == L_RCD) st_nx = ST_CAS;
            ST_CAS:  if (st_cnt == L_CAS) st_nx = ST_OPEN;
            ST_OPEN: begin
                req_ready = !ref_grant && hit && cp_ok;
                if (ref_grant || (req_valid && !hit)) st_nx = ST_CLOSE;
                else if (req_valid && req_ready) begin
                    accept = 1'b1;
                    st_nx  = ST_CAS;
                end
            end
            ST_CLOSE:  if (ras_ok) st_nx = ST_IDLE;
            ST_RF_CAS: if (st_cnt == L_CSR) st_nx = ST_RF_RAS;
            ST_RF_RAS: if (st_cnt == L_RAS) begin
                st_nx    = ST_IDLE;
                ref_done = 1'b1;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    assign go_cas    = (st_nx == ST_CAS) && (st != ST_CAS);
    assign leave_row = (st == ST_CLOSE) && (st_nx == ST_IDLE);
    assign nxt_write = accept ? req_write : cur.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            st_cnt   <= '0;
            cur      <= '0;
            rd_pend  <= 1'b0;
            rd_cnt   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st       <= st_nx;
            st_cnt   <= (st_nx != st) ? '0 : st_cnt + 1'b1;
            rd_valid <= 1'b0;
            if (accept) cur <= incoming;
            if (rd_pend) begin
                rd_cnt <= rd_cnt + 1'b1;
                if ((rd_cnt == L_CAC) || go_cas || leave_row) begin
                    rd_data  <= dram_dq_in;
                    rd_valid <= 1'b1;
                    rd_pend  <= 1'b0;
                end
            end
            if (go_cas && !nxt_write) begin
                rd_pend <= 1'b1;
                rd_cnt  <= '0;
            end
        end
    end

    assign dram_addr   = (st == ST_ROW) ? cur.row : cur.col;
    assign dram_ras_n  = !ras_low;
    assign dram_lcas_n = !lanes_lo[0];
    assign dram_ucas_n = !lanes_lo[1];
    assign dram_we_n   = !((st == ST_CAS) && cur.write);
    assign dram_dq_oe  = (st == ST_CAS) && cur.write;
    assign dram_dq_out = cur.wdata;
    assign dram_oe_n   = !rd_pend;
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int T_RAS = 12,
    parameter int T_RP  = 8,
    parameter int T_CP  = 2
) (
    input logic clk,
    input logic rst,
    input logic dram_ras_n,
    input logic dram_lcas_n,
    input logic dram_ucas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    logic [15:0] lo_run, hi_run, chi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run  <= '0;
            hi_run  <= '1;
            chi_run <= '1;
        end else begin
            lo_run  <= dram_ras_n ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1'b1);
            hi_run  <= !dram_ras_n ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1'b1);
            chi_run <= !(dram_lcas_n && dram_ucas_n) ? '0 :
                       ((chi_run == '1) ? chi_run : chi_run + 1'b1);
        end
    end

    // R4
    ras_min_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |-> (lo_run >= 16'(T_RAS)));

    // R5
    ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (hi_run >= 16'(T_RP)));

    // R6
    cas_precharge_chk: assert property (@(posedge clk) disable iff (rst)
        ((!dram_lcas_n || !dram_ucas_n) && $past(dram_lcas_n && dram_ucas_n))
        |-> (chi_run >= 16'(T_CP)));

    // R8
    read_both_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (dram_we_n && !dram_ras_n && (!dram_lcas_n || !dram_ucas_n))
        |-> (!dram_lcas_n && !dram_ucas_n));

    // R9
    cbr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_ras_n) && (!dram_lcas_n || !dram_ucas_n))
        |-> $past(!dram_lcas_n && !dram_ucas_n));

    // R7
    drive_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n));
endmodule

bind edo_ctrl edo_ctrl_chk #(.T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP)) u_chk (
    .clk(clk), .rst(rst), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_oe(dram_dq_oe));

// File: tb/sim_edo_ctrl.sv
`timescale 1ns/1ps
module sim_edo_ctrl;
    localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RAS = 12, T_RP = 8, T_CAC = 3, T_CSR = 2;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rd_valid, ref_done;
    logic [15:0] rd_data;
    logic        ref_grant = 1'b0;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out, dram_dq_in;

    always #2 clk = ~clk;

    edo_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS(T_RAS), .T_RP(T_RP),
               .T_CAC(T_CAC), .T_CSR(T_CSR)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_grant(ref_grant), .ref_done(ref_done), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_ge(input string tag, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    // ---------------- pin-level DRAM model ----------------
    logic [15:0] dmem [logic [19:0]];
    logic [9:0]  m_row, m_col;
    logic        p_ras, p_l, p_u;
    int lo_run, hi_run, chi_run, min_lo, min_hi, min_cp, ras_falls, ref_cnt, cbr_bad;

    function automatic logic [15:0] mrd(input logic [19:0] a);
        return dmem.exists(a) ? dmem[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            p_ras = 1; p_l = 1; p_u = 1;
            lo_run = 0; hi_run = 1000; chi_run = 1000;
            min_lo = 1000; min_hi = 1000; min_cp = 1000;
            ras_falls = 0; ref_cnt = 0; cbr_bad = 0;
            m_row = '0; m_col = '0;
            dram_dq_in <= '0;
        end else begin
            logic lf, uf;
            logic [19:0] a;
            logic [15:0] w;
            lf = p_l && !dram_lcas_n;
            uf = p_u && !dram_ucas_n;
            if (p_ras && !dram_ras_n) begin
                if (hi_run < min_hi) min_hi = hi_run;
                if (!dram_lcas_n || !dram_ucas_n) begin
                    ref_cnt++;
                    if (p_l || p_u) cbr_bad++;
                end else begin
                    ras_falls++;
                    m_row = dram_addr;
                end
            end
            if (!p_ras && dram_ras_n && lo_run < min_lo) min_lo = lo_run;
            if ((lf || uf) && p_l && p_u && chi_run < min_cp) min_cp = chi_run;
            if ((lf || uf) && !dram_ras_n && p_ras == 1'b0) begin
                m_col = dram_addr;
                a = {m_row, dram_addr};
                if (!dram_we_n) begin
                    w = mrd(a);
                    if (lf) w[7:0]  = dram_dq_out[7:0];
                    if (uf) w[15:8] = dram_dq_out[15:8];
                    dmem[a] = w;
                end else begin
                    dram_dq_in <= mrd(a);
                end
            end
            lo_run  = dram_ras_n ? 0 : lo_run + 1;
            hi_run  = dram_ras_n ? hi_run + 1 : 0;
            chi_run = (dram_lcas_n && dram_ucas_n) ? chi_run + 1 : 0;
            p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n;
        end
    end

    // ---------------- expectations ----------------
    logic [15:0] emem [logic [19:0]];
    logic [15:0] qd [$];
    bit          qm [$];

    function automatic logic [15:0] erd(input logic [19:0] a);
        return emem.exists(a) ? emem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] m);
        return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
    endfunction

    task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit tag7);
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (wr) emem[a] = merge(erd(a), d, m);
        else begin
            qd.push_back(erd(a));
            qm.push_back(tag7);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (qd.size() == 0) chk("R8 unexpected read", 32'(rd_data), 32'hffffffff);
            else begin
                logic [15:0] e;
                bit t;
                e = qd.pop_front();
                t = qm.pop_front();
                chk(t ? "R7 masked byte read" : "R8 read data", 32'(rd_data), 32'(e));
            end
        end
    end

    task automatic do_refresh();
        @(negedge clk);
        ref_grant = 1'b1;
        do @(negedge clk); while (!ref_done);
        ref_grant = 1'b0;
    endtask

    task automatic drain();
        while (qd.size() != 0) @(negedge clk);
        repeat (T_RAS + T_RP) @(negedge clk);
    endtask

    bit rnd_on = 0;
    initial begin
        @(negedge rst);
        while (!rnd_on) @(negedge clk);
        while (rnd_on) begin
            repeat ($urandom_range(60, 150)) @(negedge clk);
            if (rnd_on) do_refresh();
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int rf0, rc0, bad_ready;
        logic [9:0] rows [4];
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 ras_n", 32'(dram_ras_n), 1);
        chk("R10 cas_n", 32'({dram_lcas_n, dram_ucas_n}), 3);
        chk("R10 we_n/oe_n", 32'({dram_we_n, dram_oe_n}), 3);
        chk("R10 dq_oe/rd_valid", 32'({dram_dq_oe, rd_valid}), 0);

        // R1 address split
        do_req(1, 20'h12345, 16'hA5C3, 2'b11, 0);
        drain();
        chk("R1 row half", 32'(m_row), 32'h048);
        chk("R1 column half", 32'(m_col), 32'h345);
        do_req(0, 20'h12345, 16'h0, 2'b00, 0);

        // R2 page hits, R7 masked writes
        rf0 = ras_falls;
        do_req(1, 20'h12346, 16'h1111, 2'b11, 0);
        do_req(1, 20'h12346, 16'hBEEF, 2'b01, 0);
        do_req(1, 20'h12347, 16'h2222, 2'b11, 0);
        do_req(1, 20'h12347, 16'hCAFE, 2'b10, 0);
        do_req(0, 20'h12346, 16'h0, 2'b00, 1);
        do_req(0, 20'h12347, 16'h0, 2'b00, 1);
        drain();
        chk("R2 no new row open on hits", 32'(ras_falls), 32'(rf0));

        // R3 row miss
        do_req(0, 20'h4A000, 16'h0, 2'b00, 0);
        drain();
        chk("R3 one extra row open", 32'(ras_falls), 32'(rf0 + 1));

        // R9 refresh with row open
        do_req(0, 20'h4A001, 16'h0, 2'b00, 0);
        rc0 = ref_cnt;
        bad_ready = 0;
        @(negedge clk);
        ref_grant = 1'b1;
        req_addr = 20'h4A002; req_write = 1'b0;
        do begin
            @(negedge clk);
            if (req_ready) bad_ready++;
        end while (!ref_done);
        ref_grant = 1'b0;
        chk("R9 no accept while granted", 32'(bad_ready), 0);
        drain();
        chk("R9 refresh count", 32'(ref_cnt), 32'(rc0 + 1));
        chk("R9 strobe order", 32'(cbr_bad), 0);
        do_req(0, 20'h12346, 16'h0, 2'b00, 1);

        // random phase with background refresh
        rows[0] = 10'h048; rows[1] = 10'h128; rows[2] = 10'h3FF; rows[3] = 10'h000;
        rnd_on = 1;
        for (int i = 0; i < 400; i++) begin
            logic [19:0] a;
            a = {rows[$urandom_range(0, 3)], 10'($urandom_range(0, 7))};
            if ($urandom_range(0, 1) == 1)
                do_req(1, a, 16'($urandom), 2'($urandom_range(1, 3)), 0);
            else
                do_req(0, a, 16'h0, 2'b00, 0);
        end
        rnd_on = 0;
        do_req(0, 20'h003FF, 16'h0, 2'b00, 0);
        drain();
        repeat (200) @(negedge clk);
        chk_ge("R4 min row strobe low", min_lo, T_RAS);
        chk_ge("R5 min row precharge", min_hi, T_RP);
        chk_ge("R6 min column precharge", min_cp, T_CP);
        chk("R9 strobe order random", 32'(cbr_bad), 0);
        chk("R8 all reads returned", 32'(qd.size()), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule